// File: doc/BRIEF.md
# Paired Load/Store Memory Sequencer

This block takes one decoded pair-memory operation and runs it as two back-to-back transactions on a single-beat data memory port. An operation either loads two general-purpose registers from memory or stores two register values to memory. Three element forms are supported: two 64-bit doublewords, two 32-bit words that are sign-extended on load, and two 32-bit words that are zero-extended on load. The base address is formed from a register value plus a 2-bit immediate. The immediate is scaled by 16 for doubleword forms and by 8 for word forms.

The two beats are not atomic. If either beat returns an error, the operation is abandoned. Nothing is written back, and a restart pulse tells the pipeline to re-issue the entire instruction, which may repeat the first access. Load results are held internally and released together only after both beats succeed, so the base register is still intact when the instruction is re-executed. Reserved encodings are rejected with an illegal pulse and never reach memory.

Top module: `pair_mem_seq`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `wb_valid`, `done`, `restart` and `illegal` are all low.
- R2: For a doubleword form (`instr_op[1:0]`=00), the first beat address is `instr_base` + `instr_imm`*16, and the second beat address is the first address + 8.
- R3: For a word form (`instr_op[1:0]`=01 signed, 10 unsigned), the first beat address is `instr_base` + `instr_imm`*8, and the second beat address is the first address + 4.
- R4: A load (`instr_op[2]`=0) whose `instr_rd1`, `instr_rd2` and `instr_rs1` are all equal is reserved. It produces a one-cycle `illegal` pulse in the cycle after acceptance, with no memory request and no writeback. A store with equal register fields is not reserved.
- R5: Beat 0 always precedes beat 1. Each request keeps `mem_req_valid`, address and data stable until `mem_req_ready` is high. A response is accepted only in a cycle after the request handshake.
- R6: In a signed word load, the 32-bit element is taken from the upper half of `mem_rsp_rdata` when address bit 2 is 1, and from the lower half otherwise. It is then sign-extended to 64 bits.
- R7: In an unsigned word load, the element is selected as in R6 and zero-extended to 64 bits.
- R8: On a store (`mem_req_we`=1), beat 0 carries `instr_src1` and beat 1 carries `instr_src2`. A doubleword beat uses strobe 0xFF and the full value. A word beat replicates the low 32 bits into both halves, with strobe 0x0F when address bit 2 is 0 and 0xF0 when it is 1.
- R9: After both beats complete without error, `done` pulses for one cycle. For a load, `wb_valid` pulses in the same cycle with `wb_rd1`/`wb_data1` from beat 0 and `wb_rd2`/`wb_data2` from beat 1. A store never raises `wb_valid`.
- R10: An error response on either beat produces a one-cycle `restart` pulse, with no `wb_valid`, no `done`, and no further memory request. The block returns to idle in the next cycle.
- R11: `busy` is high from the cycle after acceptance until the block is idle again. `instr_valid` is ignored while `busy` is high.
- R12: `instr_op[1:0]`=11 is reserved for both loads and stores and is handled as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Operation offered (taken when not busy) |
| instr_op | input | 3 | Bit 2 store, bits 1:0 element form |
| instr_imm | input | 2 | Unscaled offset immediate |
| instr_rd1 | input | 5 | First register index |
| instr_rd2 | input | 5 | Second register index |
| instr_rs1 | input | 5 | Base register index |
| instr_base | input | 64 | Base register value |
| instr_src1 | input | 64 | First store value |
| instr_src2 | input | 64 | Second store value |
| busy | output | 1 | Operation in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_wdata | output | 64 | Store data |
| mem_req_strb | output | 8 | Byte strobes |
| mem_req_we | output | 1 | Write enable |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_rdata | input | 64 | Read data |
| mem_rsp_err | input | 1 | Response error |
| wb_valid | output | 1 | Load pair commit |
| wb_rd1 | output | 5 | First destination index |
| wb_rd2 | output | 5 | Second destination index |
| wb_data1 | output | 64 | First loaded value |
| wb_data2 | output | 64 | Second loaded value |
| done | output | 1 | Operation completed |
| restart | output | 1 | Re-execute the whole instruction |
| illegal | output | 1 | Reserved encoding rejected |

## Verification
The hardest case to reach from the ports is a fault on the second beat of a load. By then the first beat has already returned good data, yet nothing may be written back. A second hard case is a new operation offered while a beat is still waiting on a stalled request. The stimulus injects an error on a randomly chosen beat, holds off `mem_req_ready` for random stretches, and delays responses by random amounts. It also pulses `instr_valid` in the middle of a beat, then checks that the block idles cleanly once the interrupted or completed operation ends.

// File: rtl/pair_mem_pkg.sv
package pair_mem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BEAT0  = 3'd1,
        ST_BEAT1  = 3'd2,
        ST_COMMIT = 3'd3,
        ST_FAULT  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        SZ_DWORD  = 2'b00,
        SZ_WORD_S = 2'b01,
        SZ_WORD_U = 2'b10,
        SZ_RSVD   = 2'b11
    } size_kind_e;
endpackage

// File: rtl/pair_mem_agen.sv
module pair_mem_agen #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 2
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    input  logic             is_dword,
    output logic [XLEN-1:0]  addr0,
    output logic [XLEN-1:0]  addr1
);
    localparam int DW_SHIFT = 4;
    localparam int W_SHIFT  = 3;
    localparam logic [XLEN-1:0] DW_STEP = XLEN'(8);
    localparam logic [XLEN-1:0] W_STEP  = XLEN'(4);

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] offset;

    always_comb begin
        imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};
        offset  = is_dword ? (imm_ext << DW_SHIFT) : (imm_ext << W_SHIFT);
        addr0   = base + offset;
        addr1   = addr0 + (is_dword ? DW_STEP : W_STEP);
    end
endmodule

// File: rtl/pair_mem_lane.sv
module pair_mem_lane #(
    parameter int XLEN = 64
) (
    input  logic              is_dword,
    input  logic              sign_ext,
    input  logic              upper_lane,
    input  logic [XLEN-1:0]   st_src,
    input  logic [XLEN-1:0]   rd_raw,
    output logic [XLEN-1:0]   wdata,
    output logic [XLEN/8-1:0] strb,
    output logic [XLEN-1:0]   ld_val
);
    localparam int HALF   = XLEN / 2;
    localparam int STRB_W = XLEN / 8;
    localparam int HSTRB  = STRB_W / 2;

    logic [HALF-1:0] word_sel;
    logic [STRB_W-1:0] word_strb;

    genvar g;
    generate
        for (g = 0; g < STRB_W; g++) begin : g_strb
            assign word_strb[g] = (g >= HSTRB) ? upper_lane : ~upper_lane;
        end
    endgenerate

    always_comb begin
        word_sel = upper_lane ? rd_raw[XLEN-1:HALF] : rd_raw[HALF-1:0];
        if (is_dword) begin
            wdata  = st_src;
            strb   = {STRB_W{1'b1}};
            ld_val = rd_raw;
        end else begin
            wdata  = {st_src[HALF-1:0], st_src[HALF-1:0]};
            strb   = word_strb;
            ld_val = {{HALF{sign_ext & word_sel[HALF-1]}}, word_sel};
        end
    end
endmodule

// File: rtl/pair_mem_ctrl.sv
module pair_mem_ctrl
    import pair_mem_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 2,
    parameter int RA_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [2:0]       instr_op,
    input  logic [IMM_W-1:0] instr_imm,
    input  logic [RA_W-1:0]  instr_rd1,
    input  logic [RA_W-1:0]  instr_rd2,
    input  logic [RA_W-1:0]  instr_rs1,
    input  logic [XLEN-1:0]  instr_base,
    input  logic [XLEN-1:0]  instr_src1,
    input  logic [XLEN-1:0]  instr_src2,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic             rsp_err,
    input  logic [XLEN-1:0]  ld_val,
    output logic             busy,
    output logic             req_valid,
    output logic             beat1,
    output logic             is_store,
    output size_kind_e       kind,
    output logic [XLEN-1:0]  lat_base,
    output logic [IMM_W-1:0] lat_imm,
    output logic [XLEN-1:0]  st_src,
    output logic             done,
    output logic             wb_valid,
    output logic             restart,
    output logic             illegal,
    output logic [RA_W-1:0]  wb_rd1,
    output logic [RA_W-1:0]  wb_rd2,
    output logic [XLEN-1:0]  wb_data1,
    output logic [XLEN-1:0]  wb_data2
);
    typedef struct packed {
        seq_state_e       state;
        logic             sent;
        logic             store;
        size_kind_e       kind;
        logic [IMM_W-1:0] imm;
        logic [RA_W-1:0]  rd1;
        logic [RA_W-1:0]  rd2;
        logic [XLEN-1:0]  base;
        logic [XLEN-1:0]  src1;
        logic [XLEN-1:0]  src2;
        logic [XLEN-1:0]  data1;
        logic [XLEN-1:0]  data2;
        logic             illegal;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  reserved;

    always_comb begin
        reserved = (instr_op[1:0] == SZ_RSVD) ||
                   (!instr_op[2] && (instr_rd1 == instr_rd2) && (instr_rd2 == instr_rs1));
        ctl_d         = ctl_q;
        ctl_d.illegal = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (reserved) begin
                        ctl_d.illegal = 1'b1;
                    end else begin
                        ctl_d.state = ST_BEAT0;
                        ctl_d.sent  = 1'b0;
                        ctl_d.store = instr_op[2];
                        ctl_d.kind  = size_kind_e'(instr_op[1:0]);
                        ctl_d.imm   = instr_imm;
                        ctl_d.rd1   = instr_rd1;
                        ctl_d.rd2   = instr_rd2;
                        ctl_d.base  = instr_base;
                        ctl_d.src1  = instr_src1;
                        ctl_d.src2  = instr_src2;
                    end
                end
            end
            ST_BEAT0, ST_BEAT1: begin
                if (!ctl_q.sent) begin
                    if (req_ready) ctl_d.sent = 1'b1;
                end else if (rsp_valid) begin
                    ctl_d.sent = 1'b0;
                    if (rsp_err) begin
                        ctl_d.state = ST_FAULT;
                    end else if (ctl_q.state == ST_BEAT0) begin
                        ctl_d.data1 = ld_val;
                        ctl_d.state = ST_BEAT1;
                    end else begin
                        ctl_d.data2 = ld_val;
                        ctl_d.state = ST_COMMIT;
                    end
                end
            end
            ST_COMMIT: ctl_d.state = ST_IDLE;
            ST_FAULT:  ctl_d.state = ST_IDLE;
            default:   ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        busy      = ctl_q.state != ST_IDLE;
        req_valid = ((ctl_q.state == ST_BEAT0) || (ctl_q.state == ST_BEAT1)) && !ctl_q.sent;
        beat1     = ctl_q.state == ST_BEAT1;
        is_store  = ctl_q.store;
        kind      = ctl_q.kind;
        lat_base  = ctl_q.base;
        lat_imm   = ctl_q.imm;
        st_src    = beat1 ? ctl_q.src2 : ctl_q.src1;
        done      = ctl_q.state == ST_COMMIT;
        wb_valid  = done && !ctl_q.store;
        restart   = ctl_q.state == ST_FAULT;
        illegal   = ctl_q.illegal;
        wb_rd1    = ctl_q.rd1;
        wb_rd2    = ctl_q.rd2;
        wb_data1  = ctl_q.data1;
        wb_data2  = ctl_q.data2;
    end
endmodule

// File: rtl/pair_mem_seq.sv
module pair_mem_seq
    import pair_mem_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 2,
    parameter int RA_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [2:0]        instr_op,
    input  logic [IMM_W-1:0]  instr_imm,
    input  logic [RA_W-1:0]   instr_rd1,
    input  logic [RA_W-1:0]   instr_rd2,
    input  logic [RA_W-1:0]   instr_rs1,
    input  logic [XLEN-1:0]   instr_base,
    input  logic [XLEN-1:0]   instr_src1,
    input  logic [XLEN-1:0]   instr_src2,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [XLEN-1:0]   mem_req_addr,
    output logic [XLEN-1:0]   mem_req_wdata,
    output logic [XLEN/8-1:0] mem_req_strb,
    output logic              mem_req_we,
    input  logic              mem_rsp_valid,
    input  logic [XLEN-1:0]   mem_rsp_rdata,
    input  logic              mem_rsp_err,
    output logic              wb_valid,
    output logic [RA_W-1:0]   wb_rd1,
    output logic [RA_W-1:0]   wb_rd2,
    output logic [XLEN-1:0]   wb_data1,
    output logic [XLEN-1:0]   wb_data2,
    output logic              done,
    output logic              restart,
    output logic              illegal
);
    localparam int LANE_BIT = $clog2(XLEN / 8) - 1;

    logic             beat1;
    logic             is_store;
    size_kind_e       kind;
    logic [XLEN-1:0]  lat_base;
    logic [IMM_W-1:0] lat_imm;
    logic [XLEN-1:0]  st_src;
    logic [XLEN-1:0]  ld_val;
    logic [XLEN-1:0]  addr0;
    logic [XLEN-1:0]  addr1;
    logic             is_dword;

    assign is_dword     = kind == SZ_DWORD;
    assign mem_req_addr = beat1 ? addr1 : addr0;
    assign mem_req_we   = is_store;

    pair_mem_ctrl #(.XLEN(XLEN), .IMM_W(IMM_W), .RA_W(RA_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_op(instr_op), .instr_imm(instr_imm),
        .instr_rd1(instr_rd1), .instr_rd2(instr_rd2), .instr_rs1(instr_rs1),
        .instr_base(instr_base), .instr_src1(instr_src1), .instr_src2(instr_src2),
        .req_ready(mem_req_ready), .rsp_valid(mem_rsp_valid), .rsp_err(mem_rsp_err),
        .ld_val(ld_val), .busy(busy), .req_valid(mem_req_valid), .beat1(beat1),
        .is_store(is_store), .kind(kind), .lat_base(lat_base), .lat_imm(lat_imm),
        .st_src(st_src), .done(done), .wb_valid(wb_valid), .restart(restart),
        .illegal(illegal), .wb_rd1(wb_rd1), .wb_rd2(wb_rd2),
        .wb_data1(wb_data1), .wb_data2(wb_data2)
    );

    pair_mem_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) i_agen (
        .base(lat_base), .imm(lat_imm), .is_dword(is_dword),
        .addr0(addr0), .addr1(addr1)
    );

    pair_mem_lane #(.XLEN(XLEN)) i_lane (
        .is_dword(is_dword), .sign_ext(kind == SZ_WORD_S),
        .upper_lane(mem_req_addr[LANE_BIT]), .st_src(st_src), .rd_raw(mem_rsp_rdata),
        .wdata(mem_req_wdata), .strb(mem_req_strb), .ld_val(ld_val)
    );
endmodule

// File: rtl/pair_mem_seq_chk.sv
module pair_mem_seq_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic [XLEN-1:0] mem_req_wdata,
    input logic            wb_valid,
    input logic            done,
    input logic            restart,
    input logic            illegal
);
    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata));
    // R10
    restart_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !wb_valid && !done && !mem_req_valid);
    // R10
    restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !busy);
    // R4
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req_valid && !wb_valid && !busy);
    // R11
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);
    // R9
    wb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);
    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, restart, illegal}));
endmodule

bind pair_mem_seq pair_mem_seq_chk #(.XLEN(XLEN)) i_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .wb_valid(wb_valid), .done(done),
    .restart(restart), .illegal(illegal)
);

// File: tb/test_pair_mem_seq.sv
module test_pair_mem_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [2:0]  instr_op = '0;
    logic [1:0]  instr_imm = '0;
    logic [4:0]  instr_rd1 = '0, instr_rd2 = '0, instr_rs1 = '0;
    logic [63:0] instr_base = '0, instr_src1 = '0, instr_src2 = '0;
    logic        busy, mem_req_valid, mem_req_we;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic [7:0]  mem_req_strb;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        wb_valid, done, restart, illegal;
    logic [4:0]  wb_rd1, wb_rd2;
    logic [63:0] wb_data1, wb_data2;

    int checks = 0;
    int fails  = 0;
    logic [31:0] salt = 32'h1357_9bdf;

    always #4 clk = ~clk;

    pair_mem_seq i_pair_mem_seq (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] memval(input logic [63:0] a);
        logic [31:0] lo, hi;
        lo = (a[31:0] * 32'h9E37_79B9) ^ salt;
        hi = (a[31:0] ^ 32'h8000_1234) + (salt << 3);
        return {hi, lo};
    endfunction

    function automatic logic [63:0] exp_load(input logic [1:0] kd, input logic [63:0] a);
        logic [63:0] d;
        logic [31:0] w;
        d = memval(a);
        w = a[2] ? d[63:32] : d[31:0];
        if (kd == 2'b00) return d;
        if (kd == 2'b01) return {{32{w[31]}}, w};
        return {32'h0, w};
    endfunction

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [1:0] imm,
                          input logic [4:0] rd1, input logic [4:0] rd2, input logic [4:0] rs1,
                          input logic [63:0] base, input logic [63:0] s1, input logic [63:0] s2,
                          input int err_beat, input bit poke);
        logic        st, dw, rsv;
        logic [63:0] a0, ad, src, ed1, ed2, ewd;
        logic [7:0]  estb;
        bit          r;
        st  = op[2];
        dw  = op[1:0] == 2'b00;
        rsv = (op[1:0] == 2'b11) || (!st && rd1 == rd2 && rd2 == rs1);
        a0  = base + ({62'h0, imm} << (dw ? 4 : 3));
        instr_op = op; instr_imm = imm; instr_rd1 = rd1; instr_rd2 = rd2; instr_rs1 = rs1;
        instr_base = base; instr_src1 = s1; instr_src2 = s2; instr_valid = 1'b1;
        step();
        instr_valid = 1'b0;
        if (rsv) begin
            // R4 R12: reserved encoding rejected without memory access
            chk(illegal == 1'b1, (op[1:0] == 2'b11) ? "R12 illegal" : "R4 illegal", 64'(illegal), 64'h1);
            chk(!mem_req_valid && !busy && !wb_valid, "R4 no access", 64'(mem_req_valid), 64'h0);
            step();
            chk(illegal == 1'b0, "R4 one-cycle pulse", 64'(illegal), 64'h0);
            return;
        end
        instr_valid = poke;
        chk(busy == 1'b1, "R11 busy after accept", 64'(busy), 64'h1);
        chk(illegal == 1'b0, "R4 legal op not flagged", 64'(illegal), 64'h0);
        for (int b = 0; b < 2; b++) begin
            ad  = (b == 0) ? a0 : a0 + (dw ? 64'd8 : 64'd4);
            src = (b == 0) ? s1 : s2;
            ewd = dw ? src : {src[31:0], src[31:0]};
            estb = dw ? 8'hFF : (ad[2] ? 8'hF0 : 8'h0F);
            r = 1'b0;
            while (!r) begin
                chk(mem_req_valid == 1'b1, "R5 request valid held", 64'(mem_req_valid), 64'h1);
                chk(mem_req_addr == ad, dw ? "R2 address" : "R3 address", mem_req_addr, ad);
                chk(mem_req_we == st, "R8 write enable", 64'(mem_req_we), 64'(st));
                if (st) begin
                    chk(mem_req_wdata == ewd, "R8 store data", mem_req_wdata, ewd);
                    chk(mem_req_strb == estb, "R8 strobes", 64'(mem_req_strb), 64'(estb));
                end
                mem_req_ready = ($urandom % 3) != 0;
                r = mem_req_ready;
                step();
                instr_valid = 1'b0;
                mem_req_ready = 1'b0;
            end
            chk(mem_req_valid == 1'b0, "R5 no request while awaiting response", 64'(mem_req_valid), 64'h0);
            repeat ($urandom % 3) step();
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = memval(ad);
            mem_rsp_err = (err_beat == b + 1);
            step();
            mem_rsp_valid = 1'b0;
            mem_rsp_err = 1'b0;
            if (err_beat == b + 1) begin
                chk(restart == 1'b1, "R10 restart pulse", 64'(restart), 64'h1);
                chk(!wb_valid && !done && !mem_req_valid, "R10 no commit", 64'(wb_valid), 64'h0);
                step();
                chk(!busy && !restart, "R10 back to idle", 64'(busy), 64'h0);
                return;
            end
        end
        ed1 = exp_load(op[1:0], a0);
        ed2 = exp_load(op[1:0], a0 + (dw ? 64'd8 : 64'd4));
        chk(done == 1'b1, "R9 done", 64'(done), 64'h1);
        chk(wb_valid == !st, "R9 writeback only for loads", 64'(wb_valid), 64'(!st));
        chk(restart == 1'b0, "R10 no restart when clean", 64'(restart), 64'h0);
        if (!st) begin
            chk(wb_rd1 == rd1 && wb_rd2 == rd2, "R9 destination indices", {wb_rd1, wb_rd2}, {rd1, rd2});
            chk(wb_data1 == ed1, (op[1:0] == 2'b01) ? "R6 data1" : (op[1:0] == 2'b10) ? "R7 data1" : "R9 data1", wb_data1, ed1);
            chk(wb_data2 == ed2, (op[1:0] == 2'b01) ? "R6 data2" : (op[1:0] == 2'b10) ? "R7 data2" : "R9 data2", wb_data2, ed2);
        end
        step();
        chk(!busy && !done && !wb_valid, "R11 idle after op", 64'(busy), 64'h0);
        step();
        chk(!busy && !mem_req_valid, "R11 stray offer ignored", 64'(mem_req_valid), 64'h0);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [2:0] op;
        logic [4:0] a, b, c;
        int eb;
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!busy && !mem_req_valid && !wb_valid && !done && !restart && !illegal,
            "R1 reset outputs", {58'h0, busy, mem_req_valid, wb_valid, done, restart, illegal}, 64'h0);
        // directed corners
        run_op(3'b000, 2'd3, 5'd1, 5'd2, 5'd3, 64'h1000, 0, 0, 0, 1'b0);          // R2
        run_op(3'b001, 2'd1, 5'd4, 5'd5, 5'd6, 64'h2004, 0, 0, 0, 1'b0);          // R3 R6
        run_op(3'b010, 2'd2, 5'd7, 5'd8, 5'd9, 64'h3000, 0, 0, 0, 1'b0);          // R7
        run_op(3'b000, 2'd0, 5'd9, 5'd9, 5'd9, 64'h4000, 0, 0, 0, 1'b0);          // R4 reserved
        run_op(3'b100, 2'd0, 5'd9, 5'd9, 5'd9, 64'h4000, 64'hAAAA_BBBB_CCCC_DDDD,
               64'h1111_2222_3333_4444, 0, 1'b0);                                  // R4 store not reserved, R8
        run_op(3'b101, 2'd1, 5'd1, 5'd2, 5'd3, 64'h5004, 64'h0123_4567_89AB_CDEF,
               64'hFEDC_BA98_7654_3210, 0, 1'b1);                                  // R8 word, R11 poke
        run_op(3'b011, 2'd0, 5'd1, 5'd2, 5'd3, 64'h6000, 0, 0, 0, 1'b0);          // R12
        run_op(3'b111, 2'd0, 5'd1, 5'd2, 5'd3, 64'h6000, 0, 0, 0, 1'b0);          // R12
        run_op(3'b000, 2'd1, 5'd1, 5'd2, 5'd3, 64'h7000, 0, 0, 1, 1'b0);          // R10 first beat
        run_op(3'b001, 2'd1, 5'd1, 5'd2, 5'd3, 64'h7000, 0, 0, 2, 1'b1);          // R10 second beat
        run_op(3'b110, 2'd3, 5'd1, 5'd2, 5'd3, 64'h7008, 1, 2, 2, 1'b0);          // R10 store
        // constrained random
        for (int i = 0; i < 400; i++) begin
            salt = $urandom;
            op[2] = $urandom % 2;
            op[1:0] = (($urandom % 10) == 0) ? 2'b11 : 2'($urandom % 3);
            a = 5'($urandom); b = 5'($urandom); c = 5'($urandom);
            if (($urandom % 6) == 0) begin b = a; c = a; end
            eb = (($urandom % 5) == 0) ? 1 + int'($urandom % 2) : 0;
            run_op(op, 2'($urandom), a, b, c, {$urandom, $urandom}, {$urandom, $urandom},
                   {$urandom, $urandom}, eb, ($urandom % 4) == 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule